// File: doc/BRIEF.md
# E-Paper Source Row Loader

This block feeds one display row of two-bit pixel actions into the column (source) driver of an electrophoretic panel. Upstream logic hands it packed bytes over a valid/ready stream, each byte carrying four pixel actions. The loader presents each byte on an 8-bit data bus and clocks it into the driver with one CL pulse. It holds the active-low row start line `sph_n` low for the whole row. After the last byte it raises a latch pulse, so that the row moves into the driver's output latch.

Once the row is latched, the loader holds it and reports `row_loaded`. It does not time the output enable itself. `oe` follows the write-window strobe from the gate sequencer, so the column outputs are only driven while the selected gate row is on. When the window closes, `row_written` pulses for one cycle and the loader accepts the next row. Asserting `discard` while a row is held drops that row without driving it.

The controller has eight states:
- `S_IDLE` waits for the first byte.
- `S_LOW` holds the data with CL low for the setup time.
- `S_HIGH` is the CL pulse.
- `S_FETCH` waits for the next byte with CL low.
- `S_LATCH` drives LE.
- `S_HOLD` keeps the latched row.
- `S_WRITE` follows the write window.
- `S_DONE` reports completion.

Transitions:
- IDLE→LOW and FETCH→LOW when a byte is accepted.
- LOW→HIGH when the setup count expires.
- HIGH→FETCH when the pulse ends and more bytes are due.
- HIGH→LATCH when the pulse ends on the last byte.
- LATCH→HOLD when the latch count expires.
- HOLD→WRITE when the window opens.
- HOLD→IDLE on discard.
- WRITE→DONE when the window closes.
- DONE→IDLE unconditionally.

Top module: `epd_row_loader`

## Requirements
- R1: Each row takes exactly BYTES = PIXELS*PIX_BITS/BUS_W accepted bytes (200 by default) and produces exactly one CL pulse per byte.
- R2: `sph_n` goes low in the cycle after the first byte of a row is accepted. It stays low through the last CL pulse and is high at all other times.
- R3: After the last CL pulse, `le` is high for exactly LE_W consecutive cycles, once per row, with `sph_n` high and `cl` low. `row_loaded` then rises.
- R4: `oe` is high only while `write_win` is high and a latched row is held; it follows `write_win` in the same cycle.
- R5: Every accepted byte appears unchanged on `src_d`: pixel 0 sits in bits [1:0] and pixel 3 in bits [7:6]. Action codes 01 (black), 10 (white), 00 and 11 (no action) all pass through without alteration.
- R6: `src_d` is stable for CL_LO cycles with `cl` low before each CL rising edge, and it stays stable while `cl` is high. CL stays high for exactly CL_HI cycles.
- R7: If no byte is offered in the middle of a row, `cl` stays low and `sph_n` stays low until the next byte arrives. No partial byte is clocked.
- R8: While a latched row is held, `in_ready` is low and no CL pulse occurs. When `write_win` falls after an OE window, `row_written` is high for one cycle and `in_ready` is high in the following cycle.
- R9: `discard` while a row is held returns the loader to idle in the next cycle, with no OE and no `row_written`. `discard` has no effect while a row is being shifted in.
- R10: After reset, `sph_n` is high, `cl`, `le`, `oe`, `row_loaded` and `row_written` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | BUS_W | Four packed pixel actions, pixel 0 in [1:0] |
| in_ready | output | 1 | Loader accepts a byte this cycle |
| write_win | input | 1 | Write-window strobe from the gate sequencer |
| discard | input | 1 | Drop the held row without writing it |
| sph_n | output | 1 | Active-low row start, low while shifting |
| cl | output | 1 | Source driver shift clock |
| src_d | output | BUS_W | Source driver data bus |
| le | output | 1 | Latch enable pulse |
| oe | output | 1 | Output enable, follows the write window |
| row_loaded | output | 1 | A latched row is held |
| row_written | output | 1 | One-cycle pulse after the row was driven |

## Verification
Timing follows from acceptance:
- A byte accepted at a clock edge is on `src_d` after that edge, with `sph_n` low.
- CL rises CL_LO cycles later and falls CL_HI cycles after that.
- `le` begins in the cycle after the last CL falls.
- `oe` tracks `write_win` without delay.
- `row_written` is high in the cycle after the window closes.

The scoreboard records each byte at the edge where `in_ready` and `in_valid` coincide. The monitor samples 2 ns after the falling clock edge, so `oe` and the other outputs have settled. It pops the expected byte on each observed CL rise and measures pulse widths in whole cycles. The directed checks on `row_written`, `in_ready` and `oe` are made one falling edge after the stimulus that causes them.

// File: rtl/rl_pkg.sv
package rl_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOW,
        S_HIGH,
        S_FETCH,
        S_LATCH,
        S_HOLD,
        S_WRITE,
        S_DONE
    } rl_state_t;
endpackage

// File: rtl/rl_tick_timer.sv
module rl_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rl_byte_count.sv
module rl_byte_count #(
    parameter int BYTES = 200,
    localparam int CW = $clog2(BYTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(BYTES));
endmodule

// File: rtl/epd_row_loader.sv
module epd_row_loader
    import rl_pkg::*;
#(
    parameter int PIXELS   = 800,
    parameter int PIX_BITS = 2,
    parameter int BUS_W    = 8,
    parameter int CL_HI    = 1,
    parameter int CL_LO    = 1,
    parameter int LE_W     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_data,
    output logic             in_ready,
    input  logic             write_win,
    input  logic             discard,
    output logic             sph_n,
    output logic             cl,
    output logic [BUS_W-1:0] src_d,
    output logic             le,
    output logic             oe,
    output logic             row_loaded,
    output logic             row_written
);
    localparam int PER_BYTE = BUS_W / PIX_BITS;
    localparam int BYTES    = PIXELS / PER_BYTE;
    localparam int TMAX     = (CL_HI > CL_LO) ? ((CL_HI > LE_W) ? CL_HI : LE_W)
                                              : ((CL_LO > LE_W) ? CL_LO : LE_W);
    localparam int TW       = (TMAX < 2) ? 1 : $clog2(TMAX);
    localparam logic [TW-1:0] LO_LD = TW'(CL_LO - 1);
    localparam logic [TW-1:0] HI_LD = TW'(CL_HI - 1);
    localparam logic [TW-1:0] LE_LD = TW'(LE_W - 1);

    rl_state_t        state, nxt;
    logic             tmr_load, tmr_done, last_byte, accept;
    logic [TW-1:0]    tmr_val;
    logic [BUS_W-1:0] data_q;

    assign accept = in_ready && in_valid;

    rl_tick_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    rl_byte_count #(.BYTES(BYTES)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == S_LATCH),
        .inc   (accept),
        .last  (last_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (accept)
            data_q <= in_data;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE, S_FETCH: begin
                if (in_valid) begin
                    nxt      = S_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LO_LD;
                end
            end
            S_LOW: begin
                if (tmr_done) begin
                    nxt      = S_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HI_LD;
                end
            end
            S_HIGH: begin
                if (tmr_done) begin
                    if (last_byte) begin
                        nxt      = S_LATCH;
                        tmr_load = 1'b1;
                        tmr_val  = LE_LD;
                    end else begin
                        nxt = S_FETCH;
                    end
                end
            end
            S_LATCH: if (tmr_done) nxt = S_HOLD;
            S_HOLD: begin
                if (write_win)
                    nxt = S_WRITE;
                else if (discard)
                    nxt = S_IDLE;
            end
            S_WRITE: if (!write_win) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        in_ready    = (state == S_IDLE) || (state == S_FETCH);
        sph_n       = !((state == S_LOW) || (state == S_HIGH) || (state == S_FETCH));
        cl          = (state == S_HIGH);
        le          = (state == S_LATCH);
        row_loaded  = (state == S_HOLD) || (state == S_WRITE);
        oe          = row_loaded && write_win;
        row_written = (state == S_DONE);
        src_d       = data_q;
    end
endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
    parameter int BYTES = 200,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cl,
    input logic             sph_n,
    input logic             le,
    input logic             oe,
    input logic             write_win,
    input logic             discard,
    input logic             row_loaded,
    input logic             row_written,
    input logic             in_ready,
    input logic [BUS_W-1:0] src_d
);
    localparam int CW = $clog2(BYTES + 2);
    logic [CW-1:0] pulses;
    logic          cl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses <= '0;
            cl_q   <= 1'b0;
        end else begin
            cl_q <= cl;
            if (cl && !cl_q)
                pulses <= pulses + 1'b1;
            else if (sph_n && !le && !row_loaded)
                pulses <= '0;
        end
    end

    a_r1_pulses_per_row: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le) |-> pulses == CW'(BYTES));
    a_r2_sph_low_on_cl: assert property (@(posedge clk) disable iff (!rst_n)
        cl |-> !sph_n);
    a_r3_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        le |-> (sph_n && !cl));
    a_r4_oe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (write_win && row_loaded));
    a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        cl |-> $stable(src_d));
    a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_loaded) |-> (row_written || $past(discard)));
    a_r8_written_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        row_written |=> (!row_written && in_ready));
endmodule

bind epd_row_loader rl_checker #(.BYTES(BYTES), .BUS_W(BUS_W)) u_rl_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cl          (cl),
    .sph_n       (sph_n),
    .le          (le),
    .oe          (oe),
    .write_win   (write_win),
    .discard     (discard),
    .row_loaded  (row_loaded),
    .row_written (row_written),
    .in_ready    (in_ready),
    .src_d       (src_d)
);

// File: tb/tb_epd_row_loader.sv
module tb_epd_row_loader;
    localparam int BUS_W = 8;
    localparam int BYTES = 200;
    localparam int CL_HI = 2;
    localparam int CL_LO = 1;
    localparam int LE_W  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, write_win = 1'b0, discard = 1'b0;
    logic [BUS_W-1:0] in_data = '0;
    logic in_ready, sph_n, cl, le, oe, row_loaded, row_written;
    logic [BUS_W-1:0] src_d;

    int n_chk = 0, n_fail = 0;
    logic [BUS_W-1:0] exp_q[$];

    always #4 clk = ~clk;

    epd_row_loader #(.PIXELS(800), .PIX_BITS(2), .BUS_W(BUS_W),
                     .CL_HI(CL_HI), .CL_LO(CL_LO), .LE_W(LE_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .write_win(write_win), .discard(discard),
        .sph_n(sph_n), .cl(cl), .src_d(src_d), .le(le), .oe(oe),
        .row_loaded(row_loaded), .row_written(row_written)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: scoreboard pop and pulse timing, sampled after the falling edge
    int cl_cnt = 0, hi_len = 0, le_len = 0, lo_len = 0;
    logic cl_p = 1'b0, le_p = 1'b0;
    logic [BUS_W-1:0] d_p = '0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (oe && !write_win) chk(1'b0, "R4 oe without window", 1, 0);
            if (cl && !cl_p) begin
                chk(!sph_n, "R2 sph_n low at CL", sph_n, 0);
                chk(src_d == d_p && lo_len >= CL_LO, "R6 setup before CL", lo_len, CL_LO);
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", src_d, 0);
                else begin
                    logic [BUS_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(src_d == e, "R5 byte on src_d", src_d, e);
                end
                cl_cnt++;
            end
            if (cl) begin
                hi_len++;
                chk(src_d == d_p, "R6 data held while CL high", src_d, d_p);
            end
            if (!cl && cl_p) begin
                chk(hi_len == CL_HI, "R6 CL high width", hi_len, CL_HI);
                hi_len = 0;
            end
            lo_len = (cl || src_d != d_p) ? 0 : lo_len + 1;
            if (src_d != d_p && !cl) lo_len = 1;
            if (le) begin
                le_len++;
                if (!le_p) begin
                    chk(sph_n && !cl, "R3 LE with sph_n high, cl low", sph_n, 1);
                    chk(cl_cnt == BYTES, "R1 CL pulses per row", cl_cnt, BYTES);
                    cl_cnt = 0;
                end
            end
            if (!le && le_p) begin
                chk(le_len == LE_W, "R3 LE width", le_len, LE_W);
                chk(row_loaded, "R3 row_loaded after LE", row_loaded, 1);
                le_len = 0;
            end
        end
        cl_p = cl;
        le_p = le;
        d_p  = src_d;
    end

    // driver: present a byte, record it when it is accepted
    task automatic send_byte(input logic [BUS_W-1:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_row(input int k, input bit stall, input bit poke_discard);
        for (int i = 0; i < BYTES; i++) begin
            if (poke_discard && i == 10) discard = 1'b1;
            send_byte(BUS_W'(i * 37 + k * 11));
            discard = 1'b0;
            if (stall && i == 50) begin
                for (int s = 0; s < 3; s++) @(negedge clk);
                for (int s = 0; s < 4; s++) begin
                    #1;
                    chk(!cl && !sph_n, "R7 stall holds CL low, sph_n low", cl, 0);
                    @(negedge clk);
                end
            end
        end
        for (int w = 0; w < 50 && !row_loaded; w++) @(negedge clk);
        #1;
        chk(row_loaded && sph_n, "R3 row held after latch", row_loaded, 1);
    endtask

    task automatic write_row();
        write_win = 1'b1;
        #1;
        chk(oe, "R4 oe follows window", oe, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(oe && !in_ready, "R4 oe held in window", oe, 1);
        end
        write_win = 1'b0;
        #1;
        chk(!oe, "R4 oe drops with window", oe, 0);
        @(negedge clk);
        #1;
        chk(row_written, "R8 row_written pulse", row_written, 1);
        @(negedge clk);
        #1;
        chk(!row_written && in_ready, "R8 ready after write", in_ready, 1);
    endtask

    initial begin
        #1_000_000;
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(sph_n && !cl && !le && !oe && !row_loaded && !row_written && in_ready,
            "R10 reset state", {sph_n, cl, le, oe, row_loaded, in_ready}, 6'b100001);
        rst_n = 1'b1;
        @(negedge clk);
        // fixed code mix: pixel0=00, pixel1=01, pixel2=10, pixel3=11
        send_byte(8'b11_10_01_00);
        for (int i = 1; i < BYTES; i++) send_byte(BUS_W'(i * 53));
        for (int w = 0; w < 50 && !row_loaded; w++) @(negedge clk);
        // R8: no shifting while a row is held
        in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(!in_ready && !cl && sph_n, "R8 blocked while held", in_ready, 0);
        end
        in_valid = 1'b0;
        write_row();
        // R7 stall mid-row, R9 discard ignored while shifting
        send_row(1, 1'b1, 1'b1);
        discard = 1'b1;
        @(negedge clk);
        discard = 1'b0;
        #1;
        chk(!row_loaded && in_ready && !row_written && !oe, "R9 discard frees loader",
            row_loaded, 0);
        write_win = 1'b1;
        #1;
        chk(!oe, "R4 no oe when nothing held", oe, 1'b0);
        @(negedge clk);
        #1;
        chk(!row_written, "R9 no row_written after discard", row_written, 0);
        write_win = 1'b0;
        send_row(2, 1'b0, 1'b0);
        write_row();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all bytes clocked", exp_q.size(), 0);
        finish_run();
    end
endmodule